// File: doc/BRIEF.md
# External Interrupt Trigger Configuration Unit

This block sits between eight external interrupt pins and the interrupt priority controller. Each pin belongs to one interrupt group (pin 0 to group 23, up to pin 7 to group 30). A small byte-addressed configuration register holds a 2-bit trigger mode for every pin. The block samples each pin once per clock, compares the sample with the one before it, and turns that pin's activity into a one-cycle request-set strobe for its group, following the pin's mode.

Request storage and clearing are done by the priority controller. This unit only tells it when to set a request bit. Rewriting a mode therefore never removes a request that is already pending. The two edge modes behave alike: any transition of the sampled pin counts, in either direction. The two level modes also behave alike: a sampled 1 counts and a sampled 0 does not. The mode codes are still stored and read back exactly as written. Pins need no synchroniser beyond the single sample stage kept here.

Top module: `ext_trig_unit`

## Requirements
- R1: Configuration byte select 0 holds the modes of pins 0 to 3 (groups 23 to 26) and select 1 holds pins 4 to 7 (groups 27 to 30). A write to one byte leaves the other byte unchanged.
- R2: Inside a byte, the mode of the n-th pin of that group of four sits at bits 2n+1:2n.
- R3: A write takes effect at the clock edge where `cfg_wr_i` is high. From then on, `cfg_rdata_o` for the selected byte returns the written value exactly.
- R4: After reset every mode is 00, both bytes read back 0x00 and no strobe is raised.
- R5: In mode 00 (negative edge) or 01 (positive edge), a pin raises its strobe for exactly one cycle after each change of its sampled value, for a rise and for a fall alike.
- R6: In mode 10 (low level) or 11 (high level), a pin raises its strobe on every cycle in which its sample is 1, and never while its sample is 0.
- R7: A pin value present at clock edge k is sampled there, and its strobe is visible in the cycle that follows edge k. No strobe depends combinationally on the pins.
- R8: A mode write raises no strobe of its own. A pin held steady at 1 while it is switched from a level mode to an edge mode gives no strobe in the following cycle.
- R9: Each pin's strobe depends only on that pin and its own mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_i | input | NUM_PINS (8) | External interrupt pins, bit i for group 23+i |
| cfg_wr_i | input | 1 | Write strobe for the mode byte picked by `cfg_sel_i` |
| cfg_sel_i | input | SEL_W (1) | Mode byte select, for write and read |
| cfg_wdata_i | input | BYTE_W (8) | Write data: four packed 2-bit mode fields |
| cfg_rdata_o | output | BYTE_W (8) | Read data of the selected mode byte (combinational) |
| req_set_o | output | NUM_PINS (8) | Per-group request-set strobes to the priority controller |

## Verification
The hardest case to reach from the ports is a mode change while the pin stays steady. The edge detector must then reuse the sample history it kept during level mode rather than restart from zero. The stimulus holds a pin high in level mode for several cycles and rewrites its field to an edge code in a cycle where the pin does not move. It then lets the pin fall, and later switches the pin back to a level code while it is low. A reference model in the bench tracks the modes and the two most recent samples, and predicts every strobe cycle by cycle.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;

   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      TRIG_FALL = 2'b00,
      TRIG_RISE = 2'b01,
      TRIG_LOW  = 2'b10,
      TRIG_HIGH = 2'b11
   } trig_mode_e;

endpackage

// File: rtl/ext_trig_mode_regs.sv
module ext_trig_mode_regs
   import ext_trig_pkg::*;
#(
   parameter int NUM_BYTES = 2,
   parameter int BYTE_W    = 8,
   parameter int SEL_W     = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_i,
   input  logic [SEL_W-1:0]            sel_i,
   input  logic [BYTE_W-1:0]           wdata_i,
   output logic [BYTE_W-1:0]           rdata_o,
   output logic [NUM_BYTES*BYTE_W-1:0] mode_o
);

   logic [NUM_BYTES*BYTE_W-1:0] mode_q;

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_q[b*BYTE_W +: BYTE_W] <= '0;
         end else if (wr_i && (sel_i == SEL_W'(b))) begin
            mode_q[b*BYTE_W +: BYTE_W] <= wdata_i;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < NUM_BYTES; b++) begin
         if (sel_i == SEL_W'(b)) begin
            rdata_o = mode_q[b*BYTE_W +: BYTE_W];
         end
      end
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/ext_trig_pin_cell.sv
module ext_trig_pin_cell
   import ext_trig_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic              strobe_o
);

   logic smp_q;
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         smp_q  <= pin_i;
         prev_q <= smp_q;
      end
   end

   always_comb begin
      case (trig_mode_e'(mode_i))
         TRIG_FALL, TRIG_RISE: strobe_o = smp_q ^ prev_q;
         TRIG_LOW,  TRIG_HIGH: strobe_o = smp_q;
         default:              strobe_o = smp_q ^ prev_q;
      endcase
   end

endmodule

// File: rtl/ext_trig_unit.sv
module ext_trig_unit
   import ext_trig_pkg::*;
#(
   parameter  int NUM_PINS      = 8,
   parameter  int BYTE_W        = 8,
   localparam int PINS_PER_BYTE = BYTE_W / MODE_W,
   localparam int NUM_BYTES     = NUM_PINS / PINS_PER_BYTE,
   localparam int SEL_W         = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] ext_pin_i,
   input  logic                cfg_wr_i,
   input  logic [SEL_W-1:0]    cfg_sel_i,
   input  logic [BYTE_W-1:0]   cfg_wdata_i,
   output logic [BYTE_W-1:0]   cfg_rdata_o,
   output logic [NUM_PINS-1:0] req_set_o
);

   if (BYTE_W % MODE_W != 0) begin : g_bad_byte
      $error("BYTE_W must hold a whole number of mode fields");
   end
   if (NUM_PINS % PINS_PER_BYTE != 0) begin : g_bad_pins
      $error("NUM_PINS must fill whole configuration bytes");
   end

   logic [NUM_BYTES*BYTE_W-1:0] mode_flat;

   ext_trig_mode_regs #(
      .NUM_BYTES (NUM_BYTES),
      .BYTE_W    (BYTE_W),
      .SEL_W     (SEL_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cfg_wr_i),
      .sel_i   (cfg_sel_i),
      .wdata_i (cfg_wdata_i),
      .rdata_o (cfg_rdata_o),
      .mode_o  (mode_flat)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      ext_trig_pin_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_i    (ext_pin_i[i]),
         .mode_i   (mode_flat[i*MODE_W +: MODE_W]),
         .strobe_o (req_set_o[i])
      );
   end

endmodule

// File: rtl/ext_trig_unit_chk.sv
module ext_trig_unit_chk
   import ext_trig_pkg::*;
#(
   parameter  int NUM_PINS      = 8,
   parameter  int BYTE_W        = 8,
   localparam int PINS_PER_BYTE = BYTE_W / MODE_W,
   localparam int NUM_BYTES     = NUM_PINS / PINS_PER_BYTE,
   localparam int SEL_W         = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_PINS-1:0]         ext_pin_i,
   input logic                        cfg_wr_i,
   input logic [SEL_W-1:0]            cfg_sel_i,
   input logic [BYTE_W-1:0]           cfg_wdata_i,
   input logic [NUM_PINS-1:0]         req_set_o,
   input logic [NUM_BYTES*BYTE_W-1:0] mode_flat
);

   logic [1:0] age_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            age_q <= 2'd0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (mode_flat == '0 && req_set_o == '0)); // R4

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte_chk
      AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_wr_i && cfg_sel_i == SEL_W'(b))
         |=> mode_flat[b*BYTE_W +: BYTE_W] == $past(cfg_wdata_i)); // R3
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
      AST_EDGE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
         (age_q >= 2'd2 && !mode_flat[i*MODE_W+1])
         |-> req_set_o[i] == ($past(ext_pin_i[i]) ^ $past(ext_pin_i[i], 2))); // R5
      AST_LEVEL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
         (age_q >= 2'd1 && mode_flat[i*MODE_W+1])
         |-> req_set_o[i] == $past(ext_pin_i[i])); // R6
   end

endmodule

bind ext_trig_unit ext_trig_unit_chk #(
   .NUM_PINS (NUM_PINS),
   .BYTE_W   (BYTE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_pin_i   (ext_pin_i),
   .cfg_wr_i    (cfg_wr_i),
   .cfg_sel_i   (cfg_sel_i),
   .cfg_wdata_i (cfg_wdata_i),
   .req_set_o   (req_set_o),
   .mode_flat   (mode_flat)
);

// File: tb/ext_trig_unit_test.sv
module ext_trig_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ext_pin = '0;
   logic       cfg_wr = 1'b0;
   logic [0:0] cfg_sel = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic [7:0] req_set;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   ext_trig_unit uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_pin_i   (ext_pin),
      .cfg_wr_i    (cfg_wr),
      .cfg_sel_i   (cfg_sel),
      .cfg_wdata_i (cfg_wdata),
      .cfg_rdata_o (cfg_rdata),
      .req_set_o   (req_set)
   );

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } sb_item_t;

   sb_item_t   sb_q[$];
   logic [15:0] m_mode = '0;
   logic [7:0]  m_smp  = '0;
   logic [7:0]  m_prev = '0;
   logic [7:0]  cur_pins = '0;

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic [7:0] pins, input bit wr, input bit sel,
                      input logic [7:0] wd, input string tag);
      sb_item_t it;
      @(negedge clk);
      ext_pin   = pins;
      cfg_wr    = wr;
      cfg_sel   = sel;
      cfg_wdata = wd;
      cur_pins  = pins;
      m_prev = m_smp;
      m_smp  = pins;
      if (wr) m_mode[sel*8 +: 8] = wd;
      for (int i = 0; i < 8; i++) begin
         it.exp[i] = m_mode[2*i+1] ? m_smp[i] : (m_smp[i] ^ m_prev[i]);
      end
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic rd_check(input bit sel, input logic [7:0] exp, input string tag);
      cyc(cur_pins, 1'b0, sel, 8'h00, tag);
      #1;
      check8(tag, cfg_rdata, exp);
   endtask

   initial begin : monitor
      sb_item_t it;
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            check8(it.tag, req_set, it.exp);
         end
      end
   end

   initial begin : watchdog
      #2000000;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      @(negedge clk);
      check8("R4 strobe in reset", req_set, 8'h00);
      rst_n = 1'b1;
      // R4: reset modes read back as zero
      rd_check(1'b0, 8'h00, "R4 byte0");
      rd_check(1'b1, 8'h00, "R4 byte1");

      // R5/R7: default negative-edge mode, both directions strobe once
      cyc(8'h01, 0, 0, 0, "R7 first sample");
      cyc(8'h01, 0, 0, 0, "R5 steady high");
      cyc(8'h00, 0, 0, 0, "R5 fall");
      cyc(8'h00, 0, 0, 0, "R5 steady low");
      cyc(8'hF0, 0, 0, 0, "R5 rise group");
      cyc(8'h00, 0, 0, 0, "R5 fall group");

      // R2/R3: byte0 = pin0 10, pin1 11, pin2 01, pin3 00
      cyc(8'h00, 1, 0, 8'h1E, "R2 write byte0");
      rd_check(1'b0, 8'h1E, "R3 byte0");
      // R1: byte1 = pin4 00, pin5 01, pin6 10, pin7 11
      cyc(8'h00, 1, 1, 8'hE4, "R1 write byte1");
      rd_check(1'b1, 8'hE4, "R1 byte1");
      rd_check(1'b0, 8'h1E, "R1 byte0 untouched");

      // R6: level pins strobe every cycle while high
      cyc(8'h03, 0, 0, 0, "R6 level high");
      cyc(8'h03, 0, 0, 0, "R6 level hold");
      cyc(8'h03, 0, 0, 0, "R6 level hold");
      cyc(8'h00, 0, 0, 0, "R6 level low");
      cyc(8'hC0, 0, 0, 0, "R6 upper level");
      cyc(8'hC0, 0, 0, 0, "R6 upper hold");
      // R9: mixed independent pins
      cyc(8'h34, 0, 0, 0, "R9 mixed");
      cyc(8'h3C, 0, 0, 0, "R9 mixed");
      cyc(8'h08, 0, 0, 0, "R9 mixed");
      cyc(8'h00, 0, 0, 0, "R9 mixed");

      // R8: pin1 high in level mode, switched to positive edge while steady
      cyc(8'h02, 0, 0, 0, "R8 level held");
      cyc(8'h02, 0, 0, 0, "R8 level held");
      cyc(8'h02, 1, 0, 8'h16, "R8 switch to edge");
      cyc(8'h02, 0, 0, 0, "R8 steady edge");
      cyc(8'h00, 0, 0, 0, "R8 fall edge");
      cyc(8'h00, 1, 0, 8'h1E, "R8 switch to level low");
      cyc(8'h00, 0, 0, 0, "R8 idle");
      rd_check(1'b0, 8'h1E, "R3 byte0 rewrite");

      repeat (3) @(posedge clk);
      #5;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule